// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with Legacy and Revision-6 Result Models

This block performs 32-bit integer multiplication, division and leading-zero counting. It has two result models, and the `rev6` input selects between them for each operation. In the legacy model, multiply and divide results go into two internal result registers: HI holds the upper product half or the remainder, and LO holds the lower product half or the quotient. Two move-from operations copy HI or LO to the destination-write port.

In the revision-6 model no internal result register is used. A selector field picks which half of the product, or which of quotient and remainder, is written to the destination port as a single 32-bit value. In this model the opcode slot used by move-from-HI performs a count-leading-zeros instead.

Operations start with a one-cycle `start` pulse while the unit is idle. Multiply, move and count operations complete in the next cycle. Division runs a restoring divider for one cycle per bit. Every accepted operation ends with exactly one `done` pulse.

Top module: `muldiv_unit`

## Requirements
- R1: Legacy mode (`rev6`=0), op 2 (signed) and op 3 (unsigned) form the full 64-bit product. The low half goes to LO and the high half goes to HI, and there is no destination write. Op 1 writes LO to the destination and op 0 writes HI to the destination.
- R2: In revision-6 mode, ops 2 and 3 write one product half to the destination. Selector 2 gives the low 32 bits and selector 3 gives the high 32 bits. Op 2 is signed and op 3 is unsigned.
- R3: Revision-6 op 4 (signed) and op 5 (unsigned) write the quotient for selector 2 and the remainder for selector 3. Signed quotients truncate toward zero, and the remainder takes the sign of the dividend.
- R4: In legacy mode, op 4 (signed) and op 5 (unsigned) put the quotient in LO and the remainder in HI, with the same sign rules as R3.
- R5: Signed division of 0x80000000 by 0xFFFFFFFF gives the quotient 0x80000000 and the remainder 0. In legacy mode these go to LO and HI. In revision-6 mode they go to the destination, according to the selector.
- R6: A divide with a zero divisor still ends with `done`. It makes no destination write, and HI and LO keep their values.
- R7: Revision-6 op 0 writes the count of leading zeros of `opa` to the destination. A zero input gives 32.
- R8: The following cases raise `illegal` together with `done`, make no write, and leave HI and LO unchanged: ops 6 and 7 in either mode; op 1 in revision-6 mode; and, in revision-6 mode, ops 2 to 5 with a selector other than 2 or 3.
- R9: While `busy` is high, `start` is ignored, and the operation in progress completes with its own result.
- R10: `done` is a one-cycle pulse, and `wr_en` is only high together with `done`. A non-divide operation raises `done` in the cycle after `start`. After reset, `done`, `wr_en`, `illegal` and `busy` are low, and HI and LO are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation when the unit is idle |
| rev6 | input | 1 | 1 selects the revision-6 result model |
| op | input | 3 | Operation code (0 move-HI/CLZ, 1 move-LO, 2 MULT, 3 MULTU, 4 DIV, 5 DIVU) |
| sel | input | 5 | Revision-6 selector: 2 low/quotient, 3 high/remainder |
| opa | input | 32 | First operand (multiplicand, dividend, CLZ input) |
| opb | input | 32 | Second operand (multiplier, divisor) |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion of an undefined operation |
| wr_en | output | 1 | The destination write is valid this cycle |
| wr_data | output | 32 | Destination write data |

## Verification
The assertions assume that reset is held low for at least one clock before the first operation. They place no constraint on `start`, `op`, `sel` or the operands, because the unit samples these only when it accepts an operation. The stimulus deliberately pulses `start` while a division is running, to show that such pulses leave no trace. The random mix includes undefined opcodes and selectors, and it injects zero, one, all-ones and the most negative value often enough to reach the divide-by-zero and overflow paths in both modes.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MFHI  = 3'd0,
    OP_MFLO  = 3'd1,
    OP_MULT  = 3'd2,
    OP_MULTU = 3'd3,
    OP_DIV   = 3'd4,
    OP_DIVU  = 3'd5
  } op_e;

  localparam logic [4:0] SEL_LO = 5'd2;
  localparam logic [4:0] SEL_HI = 5'd3;

  typedef enum logic {ST_IDLE = 1'b0, ST_DIV = 1'b1} st_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W = 32
) (
  input  logic           signed_mode,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] prod
);
  function automatic logic [2*W-1:0] full_product(input logic sgn,
                                                  input logic [W-1:0] p,
                                                  input logic [W-1:0] q);
    logic [2*W-1:0] pe, qe;
    pe = sgn ? {{W{p[W-1]}}, p} : {{W{1'b0}}, p};
    qe = sgn ? {{W{q[W-1]}}, q} : {{W{1'b0}}, q};
    return pe * qe;
  endfunction

  assign prod = full_product(signed_mode, x, y);
endmodule

// File: rtl/muldiv_clz.sv
module muldiv_clz #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] n
);
  function automatic logic [CW-1:0] lead_zeros(input logic [W-1:0] s);
    logic [CW-1:0] c;
    c = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (s[i]) c = CW'(W - 1 - i);
    end
    return c;
  endfunction

  assign n = lead_zeros(v);
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CNTW = $clog2(W) + 1;

  logic [W-1:0]    q_r, r_r, d_r;
  logic [CNTW-1:0] cnt_r;
  logic            run_r, fin_r;
  logic [W:0]      r_sh, diff;
  logic [W-1:0]    q_nx, r_nx;

  always_comb begin
    r_sh = {r_r, q_r[W-1]};
    diff = r_sh - {1'b0, d_r};
    if (!diff[W]) begin
      r_nx = diff[W-1:0];
      q_nx = {q_r[W-2:0], 1'b1};
    end else begin
      r_nx = r_sh[W-1:0];
      q_nx = {q_r[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r   <= '0;
      r_r   <= '0;
      d_r   <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
      fin_r <= 1'b0;
    end else begin
      fin_r <= 1'b0;
      if (go) begin
        q_r   <= dividend;
        r_r   <= '0;
        d_r   <= divisor;
        cnt_r <= CNTW'(W);
        run_r <= 1'b1;
      end else if (run_r) begin
        q_r   <= q_nx;
        r_r   <= r_nx;
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CNTW'(1)) begin
          run_r <= 1'b0;
          fin_r <= 1'b1;
        end
      end
    end
  end

  assign busy = run_r;
  assign fin  = fin_r;
  assign quo  = q_r;
  assign rem  = r_r;

  // R3: a finished division leaves a remainder smaller than its divisor
  a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem < d_r));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         rev6,
  input  logic [2:0]   op,
  input  logic [4:0]   sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic         illegal,
  output logic         wr_en,
  output logic [W-1:0] wr_data
);
  import muldiv_pkg::*;

  localparam int          CW    = $clog2(W) + 1;
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  st_e          state;
  logic [W-1:0] hi_q, lo_q, wdata_q;
  logic         done_q, wr_q, ill_q;
  logic         l_rev6, l_pick_hi, l_neg_q, l_neg_r;

  logic           accept, is_mul, is_div, sgn, sel_ok, bad, div_zero, ovf, div_go;
  logic [W-1:0]   mag_a, mag_b, q_s, r_s;
  logic [2*W-1:0] prod;
  logic [CW-1:0]  clz_n;
  logic           div_busy, div_fin;
  logic [W-1:0]   div_quo, div_rem;

  always_comb begin
    accept   = start && (state == ST_IDLE);
    is_mul   = (op == OP_MULT) || (op == OP_MULTU);
    is_div   = (op == OP_DIV)  || (op == OP_DIVU);
    sgn      = (op == OP_MULT) || (op == OP_DIV);
    sel_ok   = (sel == SEL_LO) || (sel == SEL_HI);
    bad      = (op > 3'd5) || (rev6 && op == OP_MFLO) ||
               (rev6 && (is_mul || is_div) && !sel_ok);
    mag_a    = (sgn && opa[W-1]) ? -opa : opa;
    mag_b    = (sgn && opb[W-1]) ? -opb : opb;
    div_zero = (opb == '0);
    ovf      = (op == OP_DIV) && (opa == MIN_V) && (opb == '1);
    div_go   = accept && is_div && !bad && !div_zero && !ovf;
    q_s      = l_neg_q ? -div_quo : div_quo;
    r_s      = l_neg_r ? -div_rem : div_rem;
  end

  muldiv_mul #(.W(W)) u_mul (
    .signed_mode(sgn), .x(opa), .y(opb), .prod(prod)
  );

  muldiv_clz #(.W(W), .CW(CW)) u_clz (
    .v(opa), .n(clz_n)
  );

  muldiv_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(mag_a), .divisor(mag_b),
    .busy(div_busy), .fin(div_fin), .quo(div_quo), .rem(div_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hi_q      <= '0;
      lo_q      <= '0;
      wdata_q   <= '0;
      done_q    <= 1'b0;
      wr_q      <= 1'b0;
      ill_q     <= 1'b0;
      l_rev6    <= 1'b0;
      l_pick_hi <= 1'b0;
      l_neg_q   <= 1'b0;
      l_neg_r   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      ill_q  <= 1'b0;
      if (accept) begin
        if (bad) begin
          done_q <= 1'b1;
          ill_q  <= 1'b1;
        end else begin
          case (op_e'(op))
            OP_MFHI: begin
              done_q  <= 1'b1;
              wr_q    <= 1'b1;
              wdata_q <= rev6 ? {{(W-CW){1'b0}}, clz_n} : hi_q;
            end
            OP_MFLO: begin
              done_q  <= 1'b1;
              wr_q    <= 1'b1;
              wdata_q <= lo_q;
            end
            OP_MULT, OP_MULTU: begin
              done_q <= 1'b1;
              if (rev6) begin
                wr_q    <= 1'b1;
                wdata_q <= (sel == SEL_HI) ? prod[2*W-1:W] : prod[W-1:0];
              end else begin
                hi_q <= prod[2*W-1:W];
                lo_q <= prod[W-1:0];
              end
            end
            default: begin
              if (div_zero) begin
                done_q <= 1'b1;
              end else if (ovf) begin
                done_q <= 1'b1;
                if (rev6) begin
                  wr_q    <= 1'b1;
                  wdata_q <= (sel == SEL_HI) ? '0 : MIN_V;
                end else begin
                  lo_q <= MIN_V;
                  hi_q <= '0;
                end
              end else begin
                state     <= ST_DIV;
                l_rev6    <= rev6;
                l_pick_hi <= (sel == SEL_HI);
                l_neg_q   <= sgn && (opa[W-1] ^ opb[W-1]);
                l_neg_r   <= sgn && opa[W-1];
              end
            end
          endcase
        end
      end else if (state == ST_DIV && div_fin) begin
        state  <= ST_IDLE;
        done_q <= 1'b1;
        if (l_rev6) begin
          wr_q    <= 1'b1;
          wdata_q <= l_pick_hi ? r_s : q_s;
        end else begin
          lo_q <= q_s;
          hi_q <= r_s;
        end
      end
    end
  end

  assign busy    = (state == ST_DIV);
  assign done    = done_q;
  assign illegal = ill_q;
  assign wr_en   = wr_q;
  assign wr_data = wdata_q;

  // R10: the destination port is only written on a completion pulse
  a_r10_wr_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

  // R8: an undefined operation completes without any write
  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !wr_en));

  // R6: HI/LO move only on a completion pulse that has no destination write
  a_r6_hilo_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({hi_q, lo_q}) |-> (done && !wr_en));

  // R9: a running division is not disturbed until the divider reports
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_fin) |=> (busy && !done));

  // R9: the unit state and the divider agree on a division in flight
  a_r9_divider_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> busy);
endmodule

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rev6 = 1'b0;
  logic [2:0]  op = '0;
  logic [4:0]  sel = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done, illegal, wr_en;
  logic [31:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mhi = '0, mlo = '0;

  always #2.5 clk = ~clk;

  muldiv_unit #(.W(32)) u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .rev6(rev6), .op(op), .sel(sel),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .illegal(illegal),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] clz_ref(input logic [31:0] v);
    int n = 0;
    bit seen = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) seen = 1;
      if (!seen) n++;
    end
    return 32'(n);
  endfunction

  function automatic string req_of(input bit r6, input logic [2:0] o,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input bit ill);
    if (ill) return "R8";
    if ((o == 3'd4 || o == 3'd5) && b == 0) return "R6";
    if (o == 3'd4 && a == 32'h80000000 && b == 32'hffffffff) return "R5";
    case (o)
      3'd0: return r6 ? "R7" : "R1";
      3'd1: return "R1";
      3'd2, 3'd3: return r6 ? "R2" : "R1";
      default: return r6 ? "R3" : "R4";
    endcase
  endfunction

  // reference model, updates mhi/mlo for the legacy model
  task automatic model(input bit r6, input logic [2:0] o, input logic [4:0] s,
                       input logic [31:0] a, input logic [31:0] b,
                       output bit e_ill, output bit e_wr, output logic [31:0] e_d);
    longint sa, sb, sq, sr;
    logic [63:0] p, ua, ub;
    logic [31:0] q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    e_wr = 0;
    e_d = '0;
    e_ill = (o > 3'd5) || (r6 && o == 3'd1) ||
            (r6 && o >= 3'd2 && s != 5'd2 && s != 5'd3);
    if (e_ill) return;
    case (o)
      3'd0: begin e_wr = 1; e_d = r6 ? clz_ref(a) : mhi; end
      3'd1: begin e_wr = 1; e_d = mlo; end
      3'd2, 3'd3: begin
        p = (o == 3'd2) ? 64'(sa * sb) : ua * ub;
        if (r6) begin e_wr = 1; e_d = (s == 5'd3) ? p[63:32] : p[31:0]; end
        else begin mhi = p[63:32]; mlo = p[31:0]; end
      end
      default: begin
        if (b != 0) begin
          if (o == 3'd4) begin
            sq = sa / sb; sr = sa % sb;
            q = sq[31:0]; r = sr[31:0];
          end else begin
            q = a / b; r = a % b;
          end
          if (r6) begin e_wr = 1; e_d = (s == 5'd3) ? r : q; end
          else begin mlo = q; mhi = r; end
        end
      end
    endcase
  endtask

  task automatic do_op(input bit r6, input logic [2:0] o, input logic [4:0] s,
                       input logic [31:0] a, input logic [31:0] b);
    bit e_ill, e_wr;
    logic [31:0] e_d;
    string rq;
    int waits = 0;
    model(r6, o, s, a, b, e_ill, e_wr, e_d);
    rq = req_of(r6, o, a, b, e_ill);
    @(negedge clk);
    rev6 = r6; op = o; sel = s; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && waits < 100) begin
      @(negedge clk);
      waits++;
    end
    chk(done, {rq, " done seen"}, 32'(done), 32'd1);
    if (o < 3'd4 || e_ill)
      chk(waits == 0, "R10 single-cycle latency", 32'(waits), 32'd0);
    chk(illegal == e_ill, {rq, " illegal flag"}, 32'(illegal), 32'(e_ill));
    chk(wr_en == e_wr, {rq, " write enable"}, 32'(wr_en), 32'(e_wr));
    if (e_wr) chk(wr_data == e_d, {rq, " result"}, wr_data, e_d);
    @(negedge clk);
    chk(!done && !wr_en, "R10 done is one pulse", 32'(done), 32'd0);
  endtask

  task automatic read_hilo();
    do_op(1'b0, 3'd1, 5'd0, '0, '0);
    do_op(1'b0, 3'd0, 5'd0, '0, '0);
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hffffffff;
      3: return 32'h80000000;
      4: return $urandom % 16;
      default: return $urandom;
    endcase
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !wr_en && !illegal && !busy, "R10 reset outputs", {28'b0, done, wr_en, illegal, busy}, 32'd0);
    read_hilo();  // R1 HI/LO read zero after reset

    // R1 legacy products
    do_op(1'b0, 3'd2, 5'd0, 32'hfffffffd, 32'd7); read_hilo();
    do_op(1'b0, 3'd3, 5'd0, 32'hffffffff, 32'hffffffff); read_hilo();
    // R2 revision-6 halves
    do_op(1'b1, 3'd2, 5'd3, 32'hfffffffd, 32'd7);
    do_op(1'b1, 3'd3, 5'd3, 32'hffffffff, 32'h2);
    do_op(1'b1, 3'd2, 5'd2, 32'h12345678, 32'h9abcdef0);
    // R3 / R4 truncation and remainder sign
    do_op(1'b1, 3'd4, 5'd2, 32'hfffffff9, 32'd2);
    do_op(1'b1, 3'd4, 5'd3, 32'hfffffff9, 32'd2);
    do_op(1'b0, 3'd4, 5'd0, 32'd7, 32'hfffffffe); read_hilo();
    do_op(1'b0, 3'd5, 5'd0, 32'hffffffff, 32'd10); read_hilo();
    // R5 overflow in both models
    do_op(1'b1, 3'd4, 5'd2, 32'h80000000, 32'hffffffff);
    do_op(1'b1, 3'd4, 5'd3, 32'h80000000, 32'hffffffff);
    do_op(1'b0, 3'd4, 5'd0, 32'h80000000, 32'hffffffff); read_hilo();
    // R6 zero divisor keeps HI/LO
    do_op(1'b0, 3'd5, 5'd0, 32'd55, 32'd0); read_hilo();
    do_op(1'b1, 3'd4, 5'd2, 32'd55, 32'd0);
    // R7 leading zeros
    do_op(1'b1, 3'd0, 5'd0, 32'd0, 32'd0);
    do_op(1'b1, 3'd0, 5'd0, 32'd1, 32'd0);
    do_op(1'b1, 3'd0, 5'd0, 32'h80000000, 32'd0);
    // R8 undefined operations
    do_op(1'b1, 3'd2, 5'd0, 32'd3, 32'd4);
    do_op(1'b1, 3'd1, 5'd2, 32'd3, 32'd4);
    do_op(1'b0, 3'd7, 5'd2, 32'd3, 32'd4); read_hilo();

    // R9 start ignored while a division runs
    @(negedge clk);
    rev6 = 1'b0; op = 3'd5; sel = '0; opa = 32'd100; opb = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R9 busy during division", 32'(busy), 32'd1);
    op = 3'd2; opa = 32'd5; opb = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int w = 0;
      while (!done && w < 100) begin @(negedge clk); w++; end
    end
    chk(done && !wr_en, "R9 division completes", 32'(done), 32'd1);
    repeat (2) begin
      @(negedge clk);
      chk(!done, "R9 no completion for ignored start", 32'(done), 32'd0);
    end
    mlo = 32'd14; mhi = 32'd2;
    read_hilo();

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      bit r6;
      logic [2:0] o;
      logic [4:0] s;
      r6 = $urandom % 2;
      o = ($urandom % 10 == 0) ? 3'($urandom % 8) : 3'($urandom % 6);
      s = ($urandom % 8 == 0) ? 5'($urandom) : 5'(2 + $urandom % 2);
      do_op(r6, o, s, pick_val(), pick_val());
    end
    read_hilo();

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule